// File: doc/BRIEF.md
# Pseudo-Random Memory Exerciser

This block drives a memory port on its own to stress it with scrambled traffic. A start pulse latches two seeds and a transfer size. The block then runs two passes over a power-of-two range of 2^IDX_W locations. In the write pass each location is visited exactly once, in an order set by a full-period linear congruential stepper. Each location receives a word from a separate shift-register data generator.

In the read pass both generators restart from the latched seeds. The same locations are read back in the same order and compared against the regenerated data. Mismatches go into a saturating counter, and the address, expected value and observed value of the first failure are held.

Before every access the block idles for a number of cycles taken from the low bits of that access's data word. As a result, requests begin at every phase of an arbitration window of up to 2^GAP_W clocks. A host pulses start, waits for done, then reads the error count and failure record.

Top module: `rand_mem_exerciser`

## Requirements
- R1: After reset, mem_req, mem_we, busy and done are low and err_count is zero.
- R2: The location index of each access follows i' = (37*i + 23) mod 2^IDX_W with the default constants, and the first index of a pass is the latched address seed. Each pass visits every index of the range exactly once.
- R3: The data word of each access follows the shift-register step x ^= x<<13; x ^= x>>17; x ^= x<<5 on 32 bits. The first word of a pass is the latched data seed, and a seed of zero is replaced by 1.
- R4: size_sel code 0 selects byte, 1 halfword, and 2 or 3 word, and mem_size carries 0, 1 or 2 accordingly. mem_addr is the index shifted left by that code. mem_wdata carries the data word masked to the low 8, 16 or 32 bits, with the upper bits zero.
- R5: The first pass writes (mem_we high) and the second pass reads (mem_we low, mem_wdata zero). The read pass uses the same index and data sequences as the write pass.
- R6: Before each access, mem_req stays low for exactly g+1 cycles after the previous handshake or the accepted start, where g is the low GAP_W bits of that access's data word.
- R7: While mem_req is high and mem_ack is low, mem_req, mem_addr, mem_we, mem_wdata and mem_size hold their values. A transfer completes on a clock edge where mem_req and mem_ack are both high.
- R8: In the read pass, mem_rdata masked to the transfer size is compared with the masked expected word. Each mismatch increments err_count, which saturates at its all-ones value.
- R9: fail_addr, fail_exp and fail_got hold the address, masked expected value and masked observed value of the first mismatch since start. They are zero when no mismatch has occurred.
- R10: After 2^IDX_W accesses in each pass, done goes high and busy goes low. done then stays high with mem_req low until the next accepted start.
- R11: start, size_sel and both seeds are ignored while busy is high, and the run in progress continues unchanged.
- R12: With the default constants, the bank (the top two index bits) changes between at least half of the consecutive accesses of a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test when idle |
| size_sel | input | 2 | Transfer size code |
| addr_seed | input | IDX_W | First location index |
| data_seed | input | 32 | First data word |
| busy | output | 1 | Test running |
| done | output | 1 | Both passes finished |
| err_count | output | ERR_W | Saturating mismatch count |
| fail_addr | output | AW | Address of first mismatch |
| fail_exp | output | 32 | Expected value at first mismatch |
| fail_got | output | 32 | Observed value at first mismatch |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_size | output | 2 | Transfer size code of the access |
| mem_addr | output | AW | Byte address, AW = IDX_W+2 |
| mem_wdata | output | 32 | Write data, low-aligned |
| mem_ack | input | 1 | Access accepted |
| mem_rdata | input | 32 | Read data, low-aligned |

## Verification
The bound checker watches the port protocol on every cycle. It checks that requests hold steady until acknowledged, that addresses are aligned to the size code, and that upper data bits are zero for byte transfers. It also checks that no request appears while idle, that done and busy never overlap, and that the error count never falls during a run. The sequence properties need whole runs and are shown only by the bench's scenarios: exact index and data order, full coverage of the range in both passes, gap lengths, bank spread, saturation, the first-failure record, and the ignoring of start mid-run.

// File: rtl/rmx_pkg.sv
package rmx_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_ACC  = 2'd2
  } rmx_state_e;

  // size code 3 is folded onto word transfers
  function automatic logic [1:0] size_code(input logic [1:0] sel);
    return (sel == 2'd3) ? 2'd2 : sel;
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input logic [DATA_W-1:0] d,
                                                  input logic [1:0] code);
    logic [DATA_W-1:0] r;
    case (code)
      2'd0:    r = {{(DATA_W-8){1'b0}}, d[7:0]};
      2'd1:    r = {{(DATA_W-16){1'b0}}, d[15:0]};
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] xs_step(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction
endpackage

// File: rtl/rmx_addr_lcg.sv
module rmx_addr_lcg #(
  parameter int IDX_W = 6,
  parameter int MULT  = 37,
  parameter int INC   = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [IDX_W-1:0] seed,
  output logic [IDX_W-1:0] idx
);
  localparam logic [31:0]      MULT_V = 32'(MULT);
  localparam logic [31:0]      INC_V  = 32'(INC);
  // multiplier forced to 1 mod 4 and increment forced odd: full period mod 2^IDX_W
  localparam logic [IDX_W-1:0] M_EFF  = {MULT_V[IDX_W-1:2], 2'b01};
  localparam logic [IDX_W-1:0] C_EFF  = {INC_V[IDX_W-1:1], 1'b1};

  logic [IDX_W-1:0] nxt;
  assign nxt = idx * M_EFF + C_EFF;

  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (load) idx <= seed;
    else if (step) idx <= nxt;
  end
endmodule

// File: rtl/rmx_data_gen.sv
module rmx_data_gen
  import rmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [DATA_W-1:0] seed,
  output logic [DATA_W-1:0] cur,
  output logic [DATA_W-1:0] nxt
);
  assign nxt = xs_step(cur);

  always_ff @(posedge clk) begin
    if (rst)       cur <= {{(DATA_W-1){1'b0}}, 1'b1};
    else if (load) cur <= seed;
    else if (step) cur <= nxt;
  end
endmodule

// File: rtl/rmx_scoreboard.sv
module rmx_scoreboard
  import rmx_pkg::*;
#(
  parameter int AW    = 8,
  parameter int ERR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              chk,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] exp_d,
  input  logic [DATA_W-1:0] got_d,
  output logic [ERR_W-1:0]  err_count,
  output logic [AW-1:0]     fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_got
);
  logic miss;
  assign miss = chk && (exp_d != got_d);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      err_count <= '0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_got  <= '0;
    end else if (miss) begin
      if (err_count != '1) err_count <= err_count + 1'b1;
      if (err_count == '0) begin
        fail_addr <= addr;
        fail_exp  <= exp_d;
        fail_got  <= got_d;
      end
    end
  end
endmodule

// File: rtl/rand_mem_exerciser.sv
module rand_mem_exerciser
  import rmx_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int ERR_W = 8,
  parameter int GAP_W = 4,
  parameter int MULT  = 37,
  parameter int INC   = 23,
  localparam int AW   = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        size_sel,
  input  logic [IDX_W-1:0]  addr_seed,
  input  logic [DATA_W-1:0] data_seed,
  output logic              busy,
  output logic              done,
  output logic [ERR_W-1:0]  err_count,
  output logic [AW-1:0]     fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_got,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam logic [IDX_W-1:0] LAST = '1;

  rmx_state_e        state;
  logic              pass_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [GAP_W-1:0]  gap_q;
  logic [IDX_W-1:0]  aseed_q;
  logic [DATA_W-1:0] dseed_q;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] dcur, dnxt, dseed_fix, dseed_sel;
  logic [IDX_W-1:0]  aseed_sel;
  logic              accept, hs, end_pass, gen_load;

  assign accept    = (state == ST_IDLE) && start;
  assign hs        = (state == ST_ACC) && mem_ack;
  assign end_pass  = hs && (cnt_q == LAST);
  assign gen_load  = accept || (end_pass && !pass_q);
  assign dseed_fix = (data_seed == '0) ? {{(DATA_W-1){1'b0}}, 1'b1} : data_seed;
  assign aseed_sel = (state == ST_IDLE) ? addr_seed : aseed_q;
  assign dseed_sel = (state == ST_IDLE) ? dseed_fix : dseed_q;

  rmx_addr_lcg #(.IDX_W(IDX_W), .MULT(MULT), .INC(INC)) u_addr (
    .clk(clk), .rst(rst), .load(gen_load), .step(hs), .seed(aseed_sel), .idx(idx)
  );

  rmx_data_gen u_data (
    .clk(clk), .rst(rst), .load(gen_load), .step(hs), .seed(dseed_sel),
    .cur(dcur), .nxt(dnxt)
  );

  rmx_scoreboard #(.AW(AW), .ERR_W(ERR_W)) u_score (
    .clk(clk), .rst(rst), .clr(accept), .chk(hs && pass_q),
    .addr(mem_addr),
    .exp_d(size_mask(dcur, mem_size)),
    .got_d(size_mask(mem_rdata, mem_size)),
    .err_count(err_count), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_got(fail_got)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pass_q    <= 1'b0;
      cnt_q     <= '0;
      gap_q     <= '0;
      aseed_q   <= '0;
      dseed_q   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_size  <= 2'd0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            aseed_q  <= addr_seed;
            dseed_q  <= dseed_fix;
            mem_size <= size_code(size_sel);
            pass_q   <= 1'b0;
            cnt_q    <= '0;
            gap_q    <= dseed_fix[GAP_W-1:0];
            busy     <= 1'b1;
            done     <= 1'b0;
            state    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_q == '0) begin
            mem_req   <= 1'b1;
            mem_we    <= !pass_q;
            mem_addr  <= {2'b00, idx} << mem_size;
            mem_wdata <= pass_q ? '0 : size_mask(dcur, mem_size);
            state     <= ST_ACC;
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
        ST_ACC: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            if (cnt_q == LAST) begin
              if (!pass_q) begin
                pass_q <= 1'b1;
                cnt_q  <= '0;
                gap_q  <= dseed_q[GAP_W-1:0];
                state  <= ST_GAP;
              end else begin
                busy  <= 1'b0;
                done  <= 1'b1;
                state <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
              gap_q <= dnxt[GAP_W-1:0];
              state <= ST_GAP;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rmx_checker.sv
module rmx_checker #(
  parameter int AW    = 8,
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             mem_req,
  input logic             mem_ack,
  input logic             mem_we,
  input logic [1:0]       mem_size,
  input logic [AW-1:0]    mem_addr,
  input logic [31:0]      mem_wdata,
  input logic [ERR_W-1:0] err_count
);
  // R7: request and its payload hold until acknowledged
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata) && $stable(mem_size)));

  // R10: no traffic while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  // R10: done and busy never overlap
  p_done_excl_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R4: address aligned to the transfer size, no size code 3 on the port
  p_align_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ((mem_size == 2'd0) || (mem_size == 2'd1 && !mem_addr[0])
                 || (mem_size == 2'd2 && mem_addr[1:0] == 2'b00)));

  // R4: byte writes carry zero upper bits
  p_byte_data_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_size == 2'd0) |-> (mem_wdata[31:8] == 24'd0));

  // R5: read accesses carry no write data
  p_read_clean_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_wdata == 32'd0));

  // R8: mismatch count never decreases inside a run
  p_err_mono_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (err_count >= $past(err_count)));
endmodule

bind rand_mem_exerciser rmx_checker #(.AW(AW), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_we(mem_we), .mem_size(mem_size),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .err_count(err_count)
);

// File: tb/rand_mem_exerciser_tb.sv
`timescale 1ns/1ps
module rand_mem_exerciser_tb;
  localparam int IDX_W = 6;
  localparam int N     = 1 << IDX_W;
  localparam int AW    = IDX_W + 2;
  localparam int ERR_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] size_sel = 2'd0;
  logic [IDX_W-1:0] addr_seed = '0;
  logic [31:0] data_seed = '0;
  logic busy, done, mem_req, mem_we;
  logic [ERR_W-1:0] err_count;
  logic [AW-1:0] fail_addr, mem_addr;
  logic [31:0] fail_exp, fail_got, mem_wdata;
  logic [1:0] mem_size;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  rand_mem_exerciser #(.IDX_W(IDX_W), .ERR_W(ERR_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .size_sel(size_sel),
    .addr_seed(addr_seed), .data_seed(data_seed), .busy(busy), .done(done),
    .err_count(err_count), .fail_addr(fail_addr), .fail_exp(fail_exp),
    .fail_got(fail_got), .mem_req(mem_req), .mem_we(mem_we),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] mem_b [0:(N*4)-1];

  // reference model state
  int m_idx, m_sz, m_cnt, m_aseed, acc_n;
  logic [31:0] m_dat, m_dfix;
  bit m_pass, pend;
  int wcnt, low_cnt, cmode, cat;
  int bad_addr, bad_we, bad_size, bad_wdata, bad_gap, bank_chg, prev_bank;
  int exp_err;
  bit have_first;
  logic [AW-1:0] e_faddr;
  logic [31:0] e_fexp, e_fgot;
  bit cov_w [0:N-1];
  bit cov_r [0:N-1];

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [31:0] msk(input logic [31:0] d, input int sz);
    if (sz == 0) return {24'd0, d[7:0]};
    if (sz == 1) return {16'd0, d[15:0]};
    return d;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // memory responder and stream checker, acting on falling edges
  always @(negedge clk) begin
    if (busy && !mem_req) low_cnt++;
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (!pend) begin
        pend = 1'b1;
        wcnt = acc_n % 3;
        if (low_cnt != int'(m_dat[3:0]) + 1) bad_gap++;
        low_cnt = 0;
      end
      if (wcnt == 0) begin
        logic [AW-1:0] ea;
        logic [31:0] md, rv;
        pend = 1'b0;
        mem_ack = 1'b1;
        acc_n++;
        ea = AW'(m_idx << m_sz);
        md = msk(m_dat, m_sz);
        if (mem_addr != ea) bad_addr++;
        if (mem_we != !m_pass) bad_we++;
        if (int'(mem_size) != m_sz) bad_size++;
        if (!m_pass) begin
          if (mem_wdata != md) bad_wdata++;
          for (int b = 0; b < (1 << m_sz); b++) mem_b[int'(mem_addr) + b] = mem_wdata[8*b +: 8];
          cov_w[m_idx] = 1'b1;
          if (m_cnt > 0 && (m_idx >> (IDX_W-2)) != prev_bank) bank_chg++;
          prev_bank = m_idx >> (IDX_W-2);
        end else begin
          rv = '0;
          for (int b = 0; b < (1 << m_sz); b++) rv[8*b +: 8] = mem_b[int'(mem_addr) + b];
          if (cmode == 2 || (cmode == 1 && m_cnt == cat)) begin
            rv = rv ^ 32'h1;
            if (exp_err < (1 << ERR_W) - 1) exp_err++;
            if (!have_first) begin
              have_first = 1'b1;
              e_faddr = ea; e_fexp = md; e_fgot = md ^ 32'h1;
            end
          end
          mem_rdata = rv;
          cov_r[m_idx] = 1'b1;
        end
        m_cnt++;
        if (m_cnt == N) begin
          m_cnt = 0; m_pass = 1'b1; m_idx = m_aseed; m_dat = m_dfix;
        end else begin
          m_idx = (37 * m_idx + 23) % N;
          m_dat = xs(m_dat);
        end
      end else begin
        wcnt--;
      end
    end
  end

  task automatic run(input int sz_in, input int aseed, input logic [31:0] dseed,
                     input int cm, input int ca, input bit mid);
    int cw, cr;
    @(negedge clk);
    m_sz = (sz_in == 3) ? 2 : sz_in;
    m_aseed = aseed; m_idx = aseed;
    m_dfix = (dseed == 0) ? 32'd1 : dseed; m_dat = m_dfix;
    m_pass = 0; m_cnt = 0; cmode = cm; cat = ca;
    bad_addr = 0; bad_we = 0; bad_size = 0; bad_wdata = 0; bad_gap = 0;
    bank_chg = 0; exp_err = 0; have_first = 0;
    e_faddr = '0; e_fexp = '0; e_fgot = '0;
    for (int i = 0; i < N; i++) begin cov_w[i] = 0; cov_r[i] = 0; end
    size_sel = 2'(sz_in); addr_seed = IDX_W'(aseed); data_seed = dseed;
    start = 1'b1; low_cnt = 0;
    @(negedge clk);
    start = 1'b0;
    if (mid) begin
      repeat (150) @(negedge clk);
      // R11: new settings presented mid-run must be ignored
      start = 1'b1; size_sel = 2'(sz_in + 1); addr_seed = ~addr_seed;
      data_seed = 32'hDEAD_0000;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    cw = 0; cr = 0;
    for (int i = 0; i < N; i++) begin cw += cov_w[i]; cr += cov_r[i]; end
    chk(bad_addr == 0, "R2 index order", bad_addr, 0);
    chk(cw == N && cr == N, "R2 full coverage", cw + cr, 2 * N);
    chk(bad_wdata == 0, "R3 write data", bad_wdata, 0);
    chk(bad_size == 0, "R4 size code", bad_size, 0);
    chk(bad_we == 0, "R5 pass direction", bad_we, 0);
    chk(bad_gap == 0, "R6 idle gap", bad_gap, 0);
    chk(err_count == ERR_W'(exp_err), "R8 error count", err_count, exp_err);
    chk(fail_addr == e_faddr, "R9 fail address", fail_addr, e_faddr);
    chk(fail_exp == e_fexp && fail_got == e_fgot, "R9 fail values",
        fail_got ^ fail_exp, e_fgot ^ e_fexp);
    chk(done && !busy, "R10 done state", {busy, done}, 2'b01);
    chk(bank_chg >= (N - 1 + 1) / 2, "R12 bank spread", bank_chg, N / 2);
    if (mid) chk(bad_addr == 0 && bad_size == 0 && bad_gap == 0,
                 "R11 start ignored", bad_addr + bad_size + bad_gap, 0);
    repeat (5) @(negedge clk);
    chk(done && !mem_req, "R10 done holds", {done, mem_req}, 2'b10);
  endtask

  initial begin
    acc_n = 0; pend = 0; low_cnt = 0; wcnt = 0; cmode = 0; m_pass = 0;
    m_dat = 32'd1; m_idx = 0; m_sz = 0; prev_bank = 0;
    for (int i = 0; i < N * 4; i++) mem_b[i] = 8'h00;
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req && !mem_we && !busy && !done && err_count == 0,
            "R1 reset state", {mem_req, mem_we, busy, done}, 0);
        run(2, 0, 32'h1234_5678, 0, 0, 0);
        run(0, 17, 32'hCAFE_F00D, 0, 0, 0);
        run(1, 63, 32'h0BAD_BEEF, 0, 0, 0);
        run(3, 5, 32'h0, 0, 0, 0);          // R4 code 3, R3 zero seed
        run(2, 9, 32'h7777_0001, 1, 5, 0);  // R9 single mismatch
        run(1, 40, 32'h5A5A_A5A5, 2, 0, 0); // R8 saturation
        run(0, 33, 32'h0F0F_1234, 0, 0, 1); // R11 mid-run start
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule